// File: doc/BRIEF.md
# Serial Channel Command and Break Controller

This block interprets command bytes written to one asynchronous serial channel. A single byte can carry one encoded housekeeping command and any mix of transmitter and receiver enable or disable requests. The block keeps the enable state of both directions and issues single-clock reset pulses to the neighbouring logic. It gates the transmitter ready and empty indications. It also sequences a break condition on the transmit line so that the break never cuts into a character that is still queued or being shifted.

A command byte is taken on every clock in which `cmd_wr` is high. There is no back-pressure: the block accepts every write in the cycle it is presented. Its effect becomes visible on the outputs one clock later. The transmit shifter reports its state through `thr_full` and `shift_busy`. A baud generator supplies `bit_tick`, one clock wide, once per bit time. The shifter must not begin a new character while `tx_hold` is high. It drives the line low while `txd_brk_low` is high. It keeps shifting while `tx_run` is high.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: A write with bit 7 set is discarded entirely. No pulse is produced and no enable or break state changes.
- R2: Bits 6:4 select one housekeeping code. 0 is none, 1 pulses `rst_mrptr`, 2 pulses `rst_rx`, 3 pulses `rst_tx`, 4 pulses `rst_err`, 5 pulses `rst_brk_irq`. Each pulse is high for exactly the one clock after the write, and at most one pulse is high at a time.
- R3: Bit 0 enables the receiver, and `rx_search` pulses for one clock as `rx_en` rises. Bit 1 clears `rx_en` on the next clock. When bits 0 and 1 are both set, the receiver ends up disabled and there is no `rx_search` pulse.
- R4: Code 2 clears `rx_en` even if bit 0 is set in the same write.
- R5: Bit 2 sets `tx_en`. `txrdy` equals `tx_en` and not `thr_full`. `txemt` equals `txrdy` and not `shift_busy`.
- R6: Bit 3 clears `tx_en`, and with it `txrdy` and `txemt`, on the next clock. If `thr_full` or `shift_busy` was high at that write, `tx_run` stays high until both are low. When bits 2 and 3 are both set, the transmitter ends up disabled.
- R7: Code 3 clears `tx_en` and `tx_run` and cancels any break or pending break. The line is released on the next clock.
- R8: Code 6 (start break) is ignored unless `tx_en` was already high before the write. An enable in the same byte does not count.
- R9: An accepted start break waits while `thr_full` or `shift_busy` is high. `tx_hold` rises one clock after both are low. `txd_brk_low` rises on the clock after the next `bit_tick`.
- R10: Code 7 (stop break) cancels a pending break so the line never goes low. During an active break, the line is released on the clock after the next `bit_tick`. `tx_hold` then stays high for `GUARD_BITS` further ticks.
- R11: A start break received while any break sequence is in progress is ignored. A stop break with no break in progress has no effect.
- R12: A housekeeping code and enable bits in the same byte both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte |
| thr_full | input | 1 | Holding register occupied |
| shift_busy | input | 1 | Shift register sending a character |
| bit_tick | input | 1 | One pulse per bit time |
| tx_en | output | 1 | Transmitter enabled |
| rx_en | output | 1 | Receiver enabled |
| tx_run | output | 1 | Shifter allowed to run (enabled or draining) |
| rx_search | output | 1 | Pulse: receiver restarts start-bit search |
| txrdy | output | 1 | Gated ready-for-data indication |
| txemt | output | 1 | Gated transmitter-empty indication |
| txd_brk_low | output | 1 | Force the transmit line low |
| tx_hold | output | 1 | Shifter must not start a new character |
| rst_mrptr | output | 1 | Pulse: mode pointer reset |
| rst_rx | output | 1 | Pulse: receiver reset and FIFO flush |
| rst_tx | output | 1 | Pulse: transmitter reset |
| rst_err | output | 1 | Pulse: clear error status bits |
| rst_brk_irq | output | 1 | Pulse: clear break-change interrupt |

## Verification
A wrong break state shows on `tx_hold` and `txd_brk_low` at the first bit tick after the shifter empties. It shows either as a line dropped over a pending character or as a break that never arrives. A wrong drain flag shows on `tx_run` one clock after the shifter reports idle. A mis-decoded command byte shows on the pulse outputs, or on `tx_en` and `rx_en`, one clock after the write. Every fault is therefore visible within one bit time of the stimulus that exposes it.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  localparam int CMD_W    = 8;
  localparam int BIT_RSV  = 7;
  localparam int MISC_HI  = 6;
  localparam int MISC_LO  = 4;
  localparam int BIT_TXOF = 3;
  localparam int BIT_TXON = 2;
  localparam int BIT_RXOF = 1;
  localparam int BIT_RXON = 0;
  localparam int NUM_STB  = 5;

  typedef enum logic [2:0] {
    MISC_NONE   = 3'd0,
    MISC_MRPTR  = 3'd1,
    MISC_RXRST  = 3'd2,
    MISC_TXRST  = 3'd3,
    MISC_ERRRST = 3'd4,
    MISC_BRKIRQ = 3'd5,
    MISC_BRKON  = 3'd6,
    MISC_BRKOFF = 3'd7
  } misc_e;

  typedef struct packed {
    logic  valid;
    misc_e misc;
    logic  tx_off;
    logic  tx_on;
    logic  rx_off;
    logic  rx_on;
  } cmd_t;

  typedef enum logic [2:0] {
    BRK_IDLE,
    BRK_PEND,
    BRK_ARM,
    BRK_LOW,
    BRK_STOP,
    BRK_GUARD
  } brk_e;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  output cmd_t               cmd,
  output logic [NUM_STB-1:0] stb
);
  logic [NUM_STB-1:0] stb_d;

  // Field split; a set reserved bit voids the whole byte.
  always_comb begin
    cmd.valid  = cmd_wr && !cmd_data[BIT_RSV];
    cmd.misc   = misc_e'(cmd_data[MISC_HI:MISC_LO]);
    cmd.tx_off = cmd_data[BIT_TXOF];
    cmd.tx_on  = cmd_data[BIT_TXON];
    cmd.rx_off = cmd_data[BIT_RXOF];
    cmd.rx_on  = cmd_data[BIT_RXON];
  end

  // Pulse k answers housekeeping code k+1.
  for (genvar k = 0; k < NUM_STB; k++) begin : g_stb
    assign stb_d[k] = cmd.valid && (3'(cmd.misc) == 3'(k + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= '0;
    else        stb <= stb_d;
  end
endmodule

// File: rtl/uart_chan_enable.sv
module uart_chan_enable
  import uart_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic thr_full,
  input  logic shift_busy,
  output logic tx_en,
  output logic tx_run,
  output logic rx_en,
  output logic rx_search
);
  logic busy;
  logic rx_off_now, rx_on_now;
  logic tx_rst_now, tx_off_now, tx_on_now;
  logic drain;

  assign busy       = thr_full || shift_busy;
  // Disable (or a reset) always beats enable in one byte.
  assign rx_off_now = cmd.valid && (cmd.rx_off || cmd.misc == MISC_RXRST);
  assign rx_on_now  = cmd.valid && cmd.rx_on && !rx_off_now;
  assign tx_rst_now = cmd.valid && cmd.misc == MISC_TXRST;
  assign tx_off_now = (cmd.valid && cmd.tx_off) || tx_rst_now;
  assign tx_on_now  = cmd.valid && cmd.tx_on && !tx_off_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en     <= 1'b0;
      rx_search <= 1'b0;
    end else begin
      rx_search <= rx_on_now;
      if (rx_off_now)     rx_en <= 1'b0;
      else if (rx_on_now) rx_en <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      drain <= 1'b0;
    end else begin
      if (tx_off_now)     tx_en <= 1'b0;
      else if (tx_on_now) tx_en <= 1'b1;

      if (tx_rst_now || tx_on_now)  drain <= 1'b0;
      else if (tx_off_now && tx_en) drain <= busy;
      else                          drain <= drain && busy;
    end
  end

  assign tx_run = tx_en || drain;
endmodule

// File: rtl/uart_break_seq.sv
module uart_break_seq
  import uart_cmd_pkg::*;
#(
  parameter int GUARD_BITS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic tx_en,
  input  logic thr_full,
  input  logic shift_busy,
  input  logic bit_tick,
  output logic brk_low,
  output logic tx_hold
);
  localparam int GCNT_W = (GUARD_BITS > 1) ? $clog2(GUARD_BITS) : 1;
  localparam logic [GCNT_W-1:0] GCNT_LAST = GCNT_W'(GUARD_BITS - 1);

  brk_e              st_q, st_d;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic              start_ok, stop_req, cancel, busy;

  assign busy     = thr_full || shift_busy;
  assign start_ok = cmd.valid && cmd.misc == MISC_BRKON && tx_en;
  assign stop_req = cmd.valid && cmd.misc == MISC_BRKOFF;
  assign cancel   = cmd.valid && cmd.misc == MISC_TXRST;

  always_comb begin
    st_d   = st_q;
    gcnt_d = gcnt_q;
    unique case (st_q)
      BRK_IDLE: if (start_ok) st_d = BRK_PEND;
      BRK_PEND: begin
        if (stop_req)  st_d = BRK_IDLE;
        else if (!busy) st_d = BRK_ARM;
      end
      BRK_ARM: begin
        if (stop_req)      st_d = BRK_IDLE;
        else if (bit_tick) st_d = BRK_LOW;
      end
      BRK_LOW: if (stop_req) st_d = BRK_STOP;
      BRK_STOP: begin
        if (bit_tick) begin
          st_d   = BRK_GUARD;
          gcnt_d = '0;
        end
      end
      BRK_GUARD: begin
        if (bit_tick) begin
          if (gcnt_q == GCNT_LAST) st_d = BRK_IDLE;
          else                     gcnt_d = gcnt_q + 1'b1;
        end
      end
      default: st_d = BRK_IDLE;
    endcase
    if (cancel) st_d = BRK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BRK_IDLE;
      gcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      gcnt_q <= gcnt_d;
    end
  end

  assign brk_low = (st_q == BRK_LOW) || (st_q == BRK_STOP);
  assign tx_hold = (st_q == BRK_ARM) || brk_low || (st_q == BRK_GUARD);
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int GUARD_BITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             thr_full,
  input  logic             shift_busy,
  input  logic             bit_tick,
  output logic             tx_en,
  output logic             rx_en,
  output logic             tx_run,
  output logic             rx_search,
  output logic             txrdy,
  output logic             txemt,
  output logic             txd_brk_low,
  output logic             tx_hold,
  output logic             rst_mrptr,
  output logic             rst_rx,
  output logic             rst_tx,
  output logic             rst_err,
  output logic             rst_brk_irq
);
  cmd_t               cmd;
  logic [NUM_STB-1:0] stb;

  uart_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .cmd      (cmd),
    .stb      (stb)
  );

  uart_chan_enable u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .thr_full   (thr_full),
    .shift_busy (shift_busy),
    .tx_en      (tx_en),
    .tx_run     (tx_run),
    .rx_en      (rx_en),
    .rx_search  (rx_search)
  );

  uart_break_seq #(.GUARD_BITS(GUARD_BITS)) u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .tx_en      (tx_en),
    .thr_full   (thr_full),
    .shift_busy (shift_busy),
    .bit_tick   (bit_tick),
    .brk_low    (txd_brk_low),
    .tx_hold    (tx_hold)
  );

  assign rst_mrptr   = stb[0];
  assign rst_rx      = stb[1];
  assign rst_tx      = stb[2];
  assign rst_err     = stb[3];
  assign rst_brk_irq = stb[4];

  assign txrdy = tx_en && !thr_full;
  assign txemt = txrdy && !shift_busy;
endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_en,
  input logic rx_en,
  input logic tx_run,
  input logic rx_search,
  input logic txrdy,
  input logic txemt,
  input logic txd_brk_low,
  input logic tx_hold,
  input logic rst_mrptr,
  input logic rst_rx,
  input logic rst_tx,
  input logic rst_err,
  input logic rst_brk_irq
);
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_mrptr, rst_rx, rst_tx, rst_err, rst_brk_irq}));

  p_search_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_search |-> rx_en);

  p_rxrst_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rx |-> !rx_en);

  p_emt_in_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txemt |-> txrdy);

  p_rdy_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txrdy |-> tx_en);

  p_txrst_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_tx |-> (!txd_brk_low && !tx_run && !tx_hold));

  p_low_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txd_brk_low |-> tx_hold);

  p_low_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_brk_low) |-> $past(bit_tick));

  p_release_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd_brk_low) && !rst_tx) |-> $past(bit_tick));
endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick    (bit_tick),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .tx_run      (tx_run),
  .rx_search   (rx_search),
  .txrdy       (txrdy),
  .txemt       (txemt),
  .txd_brk_low (txd_brk_low),
  .tx_hold     (tx_hold),
  .rst_mrptr   (rst_mrptr),
  .rst_rx      (rst_rx),
  .rst_tx      (rst_tx),
  .rst_err     (rst_err),
  .rst_brk_irq (rst_brk_irq)
);

// File: tb/sim_uart_cmd_ctrl.sv
module sim_uart_cmd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       thr_full = 1'b0;
  logic       shift_busy = 1'b0;
  logic       bit_tick = 1'b0;
  logic tx_en, rx_en, tx_run, rx_search, txrdy, txemt, txd_brk_low, tx_hold;
  logic rst_mrptr, rst_rx, rst_tx, rst_err, rst_brk_irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  uart_cmd_ctrl #(.GUARD_BITS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .thr_full(thr_full), .shift_busy(shift_busy), .bit_tick(bit_tick),
    .tx_en(tx_en), .rx_en(rx_en), .tx_run(tx_run), .rx_search(rx_search),
    .txrdy(txrdy), .txemt(txemt), .txd_brk_low(txd_brk_low), .tx_hold(tx_hold),
    .rst_mrptr(rst_mrptr), .rst_rx(rst_rx), .rst_tx(rst_tx),
    .rst_err(rst_err), .rst_brk_irq(rst_brk_irq)
  );

  function automatic logic [4:0] strobes();
    return {rst_brk_irq, rst_err, rst_tx, rst_rx, rst_mrptr};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_data = 8'h00;
    thr_full = 1'b0; shift_busy = 1'b0; bit_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = d;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("reset", "tx_en", 8'(tx_en), 8'd0);
    chk("reset", "rx_en", 8'(rx_en), 8'd0);
    chk("reset", "txrdy", 8'(txrdy), 8'd0);
    chk("reset", "brk", 8'({txd_brk_low, tx_hold, tx_run}), 8'd0);
    chk("reset", "strobes", 8'(strobes()), 8'd0);
  endtask

  task automatic t_reserved_r1();
    do_reset();
    wr(8'hC5);
    chk("R1", "strobes", 8'(strobes()), 8'd0);
    chk("R1", "enables", 8'({tx_en, rx_en, rx_search}), 8'd0);
    wr(8'h04);
    wr(8'hE0);
    @(negedge clk);
    tick();
    chk("R1", "no break", 8'({txd_brk_low, tx_hold}), 8'd0);
  endtask

  task automatic t_codes_r2();
    do_reset();
    for (int c = 1; c <= 5; c++) begin
      wr(8'(c << 4));
      chk("R2", $sformatf("code %0d pulse", c), 8'(strobes()), 8'(1 << (c - 1)));
      @(negedge clk);
      chk("R2", $sformatf("code %0d width", c), 8'(strobes()), 8'd0);
    end
    wr(8'h00);
    chk("R2", "code 0", 8'(strobes()), 8'd0);
  endtask

  task automatic t_rx_r3();
    do_reset();
    wr(8'h01);
    chk("R3", "enable", 8'({rx_en, rx_search}), 8'b11);
    @(negedge clk);
    chk("R3", "search width", 8'({rx_en, rx_search}), 8'b10);
    wr(8'h02);
    chk("R3", "disable", 8'(rx_en), 8'd0);
    wr(8'h01);
    wr(8'h03);
    chk("R3", "both bits", 8'({rx_en, rx_search}), 8'b00);
  endtask

  task automatic t_rxrst_r4();
    do_reset();
    wr(8'h01);
    wr(8'h21);
    chk("R4", "reset wins", 8'({rx_en, rst_rx, rx_search}), 8'b010);
  endtask

  task automatic t_gate_r5();
    do_reset();
    wr(8'h04);
    #1;
    chk("R5", "rdy/emt idle", 8'({tx_en, txrdy, txemt}), 8'b111);
    shift_busy = 1'b1; #1;
    chk("R5", "shifting", 8'({txrdy, txemt}), 8'b10);
    thr_full = 1'b1; #1;
    chk("R5", "held", 8'({txrdy, txemt}), 8'b00);
  endtask

  task automatic t_disable_r6();
    do_reset();
    wr(8'h04);
    shift_busy = 1'b1;
    wr(8'h08);
    chk("R6", "disabled", 8'({tx_en, txrdy, txemt}), 8'b000);
    chk("R6", "draining", 8'(tx_run), 8'd1);
    shift_busy = 1'b0;
    @(negedge clk);
    chk("R6", "drained", 8'(tx_run), 8'd0);
    wr(8'h04);
    wr(8'h0C);
    chk("R6", "both bits", 8'(tx_en), 8'd0);
  endtask

  task automatic t_txrst_r7();
    do_reset();
    wr(8'h04);
    shift_busy = 1'b1;
    wr(8'h60);
    wr(8'h30);
    chk("R7", "pulse/en/run", 8'({rst_tx, tx_en, tx_run}), 8'b100);
    shift_busy = 1'b0;
    tick();
    tick();
    chk("R7", "pending cancelled", 8'({txd_brk_low, tx_hold}), 8'd0);
    wr(8'h04);
    wr(8'h60);
    tick();
    chk("R7", "break active", 8'(txd_brk_low), 8'd1);
    wr(8'h30);
    chk("R7", "line released", 8'({txd_brk_low, tx_hold}), 8'd0);
  endtask

  task automatic t_needs_en_r8();
    do_reset();
    wr(8'h60);
    tick();
    chk("R8", "disabled tx", 8'({txd_brk_low, tx_hold}), 8'd0);
    wr(8'h64);
    tick();
    chk("R8", "same-byte enable", 8'({txd_brk_low, tx_hold}), 8'd0);
  endtask

  task automatic t_break_r9_r10_r11();
    do_reset();
    wr(8'h04);
    thr_full = 1'b1;
    wr(8'h60);
    chk("R9", "pending", 8'({txd_brk_low, tx_hold}), 8'b00);
    tick();
    chk("R9", "tick while full", 8'({txd_brk_low, tx_hold}), 8'b00);
    thr_full = 1'b0;
    @(negedge clk);
    chk("R9", "armed", 8'({txd_brk_low, tx_hold}), 8'b01);
    tick();
    chk("R9", "low after tick", 8'({txd_brk_low, tx_hold}), 8'b11);
    wr(8'h60);
    tick();
    chk("R11", "restart ignored", 8'({txd_brk_low, tx_hold}), 8'b11);
    wr(8'h70);
    chk("R10", "low until tick", 8'(txd_brk_low), 8'd1);
    tick();
    chk("R10", "released, guard", 8'({txd_brk_low, tx_hold}), 8'b01);
    tick();
    chk("R10", "guard over", 8'({txd_brk_low, tx_hold}), 8'b00);
  endtask

  task automatic t_stop_cases_r10_r11();
    do_reset();
    wr(8'h04);
    thr_full = 1'b1;
    wr(8'h60);
    wr(8'h70);
    thr_full = 1'b0;
    @(negedge clk);
    tick();
    tick();
    chk("R10", "pending cancelled", 8'({txd_brk_low, tx_hold}), 8'd0);
    wr(8'h70);
    chk("R11", "stop idle", 8'({txd_brk_low, tx_hold, strobes()}), 8'd0);
    chk("R11", "stop idle enables", 8'(tx_en), 8'd1);
  endtask

  task automatic t_multi_r12();
    do_reset();
    wr(8'h45);
    chk("R12", "err pulse", 8'(strobes()), 8'b01000);
    chk("R12", "enables", 8'({tx_en, rx_en, rx_search}), 8'b111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_reserved_r1();
    t_codes_r2();
    t_rx_r3();
    t_rxrst_r4();
    t_gate_r5();
    t_disable_r6();
    t_txrst_r7();
    t_needs_en_r8();
    t_break_r9_r10_r11();
    t_stop_cases_r10_r11();
    t_multi_r12();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule